// File: doc/BRIEF.md
# Tone Pair Guard-Time Validator

This block stands in for the analog steering network behind a dual-tone receiver. A frequency detector upstream raises `est` while it sees a legal tone pair and presents the pair's row and column indices. The block decides when that pair counts as a real digit, and when the line has been quiet long enough for the next digit.

A pair is accepted once `est` has stayed high through a programmable number of time ticks. The block then latches the pair's 4-bit code, waits a fixed settle interval, and raises the delayed-steering flag `steer_dly` together with a one-cycle `rx_valid` pulse. Status logic downstream can use that pulse to set its receive-full flag. The flag stays up, and the code stays frozen, until `est` has been low for a second, independently programmable number of ticks. Shorter gaps are treated as dropouts of the same digit.

Time is measured in ticks from an internal prescaler that divides the clock by `TICK_DIV`. With a 1 ms tick, guard values of 40 accept typical tones and pauses, and shorter settings reject bursts of 20 ms or less.

Top module: `tone_guard_validator`

## Requirements
- R1: After reset `digit` is 0000, `steer_dly` is 0 and `rx_valid` is 0.
- R2: While the block is free, an `est` burst spanning fewer than `present_ticks` prescaler ticks registers nothing. `digit` keeps its value and no `rx_valid` pulse occurs.
- R3: While the block is free, `est` held high for at least `present_ticks` ticks registers the pair present at the accepting tick. Only such an acceptance changes `digit`.
- R4: `row` index 0..3 stands for 697/770/852/941 Hz and `col` index 0..3 stands for 1209/1336/1477/1633 Hz. For row 0..2 and col 0..2, the code is 3*row+col+1, which gives 0001..1001.
- R5: Row 3 with col 1 gives 1010, with col 0 gives 1011, and with col 2 gives 1100.
- R6: Col 3 gives 1101, 1110, 1111 and 0000 for rows 0, 1, 2 and 3 respectively.
- R7: `digit` is updated first. `steer_dly` rises exactly `SETTLE_TICKS*TICK_DIV` clock cycles later, with `digit` unchanged at the rise.
- R8: `rx_valid` is high for exactly one cycle, the first cycle in which `steer_dly` is high. It occurs at no other time.
- R9: While `steer_dly` is high, an `est` gap spanning fewer than `absent_ticks` ticks keeps `steer_dly` high and `digit` unchanged. A different pair arriving after such a gap is not accepted.
- R10: While `steer_dly` is high, `est` low for at least `absent_ticks` ticks clears `steer_dly`. After that a new pair can be accepted.
- R11: `present_ticks` and `absent_ticks` act independently and take effect as soon as they are changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| est | input | 1 | High while the detector sees a valid tone pair |
| row | input | 2 | Low-group tone index of the detected pair |
| col | input | 2 | High-group tone index of the detected pair |
| present_ticks | input | GW | Tone-present guard, in ticks |
| absent_ticks | input | GW | Tone-absent guard, in ticks |
| digit | output | 4 | Latched code of the last accepted pair |
| steer_dly | output | 1 | Delayed-steering flag |
| rx_valid | output | 1 | One-cycle pulse when `steer_dly` rises |

## Verification
Two functions can fall in the same cycle: the expiry of the absent guard, and the return of `est` carrying the next digit. If `est` is high at the expiring tick, the gap counter clears and the old digit is kept. If `est` comes back one tick later, the new digit counts from the start of its own present guard. Random pause lengths therefore stay clearly on one side of the guard. Directed dropouts of exactly one tick less than the absent guard are followed at once by a different pair, and the check is that the latched code is not overwritten. A second matter is that the settle interval and the pulse land together. This is judged by measuring, at the ports, the distance in cycles from the code change to the pulse.

// File: rtl/tone_guard_validator.sv
module tone_guard_validator #(
  parameter int TICK_DIV     = 50000,
  parameter int GW           = 8,
  parameter int SETTLE_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          est,
  input  logic [1:0]    row,
  input  logic [1:0]    col,
  input  logic [GW-1:0] present_ticks,
  input  logic [GW-1:0] absent_ticks,
  output logic [3:0]    digit,
  output logic          steer_dly,
  output logic          rx_valid
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SW = $clog2(SETTLE_TICKS + 1);
  localparam int CW = (GW > SW) ? GW : SW;

  typedef enum logic [1:0] {FREE, SETTLE, HELD} state_t;

  state_t        st;
  logic [PW-1:0] pre;
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_nx;
  logic          tick;

  assign tick      = (pre == PW'(TICK_DIV - 1));
  assign cnt_nx    = {1'b0, cnt} + 1'b1;
  assign steer_dly = (st == HELD);

  function automatic logic [3:0] pair_code(input logic [1:0] r, input logic [1:0] c);
    case ({r, c})
      4'b1100: pair_code = 4'd11;
      4'b1101: pair_code = 4'd10;
      4'b1110: pair_code = 4'd12;
      4'b1111: pair_code = 4'd0;
      4'b0011: pair_code = 4'd13;
      4'b0111: pair_code = 4'd14;
      4'b1011: pair_code = 4'd15;
      default: pair_code = 4'(r * 3 + c + 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FREE;
      cnt      <= '0;
      digit    <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        FREE: begin
          if (!est) cnt <= '0;
          else if (tick) begin
            if (cnt_nx >= (CW+1)'(present_ticks)) begin
              digit <= pair_code(row, col);
              st    <= SETTLE;
              cnt   <= '0;
            end else cnt <= cnt_nx[CW-1:0];
          end
        end
        SETTLE: begin
          if (tick) begin
            if (cnt_nx >= (CW+1)'(SETTLE_TICKS)) begin
              st       <= HELD;
              cnt      <= '0;
              rx_valid <= 1'b1;
            end else cnt <= cnt_nx[CW-1:0];
          end
        end
        default: begin
          if (est) cnt <= '0;
          else if (tick) begin
            if (cnt_nx >= (CW+1)'(absent_ticks)) begin
              st  <= FREE;
              cnt <= '0;
            end else cnt <= cnt_nx[CW-1:0];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tone_guard_validator_chk.sv
module tone_guard_validator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       est,
  input logic [3:0] digit,
  input logic       steer_dly,
  input logic       rx_valid
);
  p_pulse_at_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (steer_dly && !$past(steer_dly)));

  p_rise_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_dly) |-> rx_valid);

  p_code_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_dly) |-> $stable(digit));

  p_code_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_dly && $past(steer_dly)) |-> $stable(digit));

  p_drop_needs_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_dly) |-> !$past(est));

  p_code_needs_tone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(digit) |-> ($past(est) && !steer_dly));
endmodule

bind tone_guard_validator tone_guard_validator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .est(est), .digit(digit),
  .steer_dly(steer_dly), .rx_valid(rx_valid)
);

// File: tb/tone_guard_validator_test.sv
module tone_guard_validator_test;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int ST = 3;
  localparam int GW = 8;

  logic clk = 1'b0, rst_n = 1'b0, est = 1'b0;
  logic [1:0] row = '0, col = '0;
  logic [GW-1:0] pg = 8'd5, ag = 8'd7;
  logic [3:0] digit;
  logic steer_dly, rx_valid;

  int checks = 0, errors = 0, pulses = 0, cyc = 0, chg_cyc = 0;
  logic chg_pend = 1'b0, prev_flag = 1'b0, prev_rx = 1'b0;
  logic [3:0] last_digit = '0, pulse_code = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_guard_validator #(.TICK_DIV(TD), .GW(GW), .SETTLE_TICKS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .est(est), .row(row), .col(col),
    .present_ticks(pg), .absent_ticks(ag),
    .digit(digit), .steer_dly(steer_dly), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int r, input int c);
    if (c == 3) return (r == 3) ? 0 : 13 + r;
    if (r == 3) return (c == 0) ? 11 : (c == 1) ? 10 : 12;
    return r * 3 + c + 1;
  endfunction

  function automatic string map_req(input int r, input int c);
    if (c == 3) return "R6";
    if (r == 3) return "R5";
    return "R4";
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (digit != last_digit) begin
        chg_cyc  = cyc;
        chg_pend = 1'b1;
      end
      if (rx_valid) begin
        pulses++;
        pulse_code = digit;
        chk(steer_dly && !prev_flag && !prev_rx, "R8 pulse on rise", int'(prev_rx), 0);
        if (chg_pend)
          chk(cyc - chg_cyc == ST * TD, "R7 settle delay", cyc - chg_cyc, ST * TD);
        chg_pend = 1'b0;
      end
      if (steer_dly && !prev_flag && !rx_valid)
        chk(1'b0, "R8 rise without pulse", 0, 1);
    end
    last_digit = digit;
    prev_flag  = steer_dly;
    prev_rx    = rx_valid;
  end

  task automatic drive(input int r, input int c, input int on, input int off);
    @(negedge clk);
    row = 2'(r); col = 2'(c); est = 1'b1;
    repeat (on) @(negedge clk);
    est = 1'b0;
    repeat (off) @(negedge clk);
  endtask

  function automatic int on_ok();  return (int'(pg) + ST + 2) * TD; endfunction
  function automatic int off_ok(); return (int'(ag) + 2) * TD;      endfunction

  task automatic digit_trial(input int r, input int c, input int extra);
    int p0 = pulses;
    drive(r, c, on_ok() + extra, off_ok() + extra);
    chk(pulses == p0 + 1, "R3 accepted once", pulses - p0, 1);
    chk(int'(pulse_code) == exp_code(r, c), map_req(r, c), int'(pulse_code), exp_code(r, c));
    chk(!steer_dly, "R10 flag cleared", int'(steer_dly), 0);
  endtask

  task automatic short_trial(input int r, input int c, input int len);
    int p0 = pulses;
    logic [3:0] d0 = digit;
    drive(r, c, len, 3 * TD);
    chk(pulses == p0 && digit == d0, "R2 short burst ignored", int'(digit), int'(d0));
  endtask

  task automatic dropout_trial();
    int p0 = pulses;
    logic [3:0] keep;
    @(negedge clk);
    row = 2'd1; col = 2'd1; est = 1'b1;
    repeat (on_ok()) @(negedge clk);
    keep = digit;
    est = 1'b0;
    repeat ((int'(ag) - 1) * TD) @(negedge clk);
    row = 2'd2; col = 2'd2; est = 1'b1;
    repeat (on_ok()) @(negedge clk);
    chk(steer_dly == 1'b1, "R9 flag held", int'(steer_dly), 1);
    chk(digit == keep && int'(keep) == exp_code(1, 1), "R9 code kept", int'(digit), exp_code(1, 1));
    chk(pulses == p0 + 1, "R9 no new digit", pulses - p0, 1);
    est = 1'b0;
    repeat (off_ok()) @(negedge clk);
    chk(!steer_dly, "R10 flag cleared after gap", int'(steer_dly), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int r, c;
    r = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(digit == 4'd0 && !steer_dly && !rx_valid, "R1 reset state", int'(digit), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(digit == 4'd0 && !steer_dly && !rx_valid, "R1 after release", int'(digit), 0);

    short_trial(0, 0, (int'(pg) - 1) * TD);
    short_trial(2, 1, TD);

    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        digit_trial(i, j, 0);

    short_trial(3, 3, (int'(pg) - 1) * TD);
    dropout_trial();

    pg = 8'd3; ag = 8'd10;
    short_trial(0, 2, (int'(pg) - 1) * TD);
    digit_trial(2, 0, 0);
    dropout_trial();
    chk(pulse_code == 4'(exp_code(1, 1)), "R11 new guards", int'(pulse_code), exp_code(1, 1));

    pg = 8'd5; ag = 8'd7;
    for (int k = 0; k < 40; k++) begin
      r = int'($urandom_range(3, 0));
      c = int'($urandom_range(3, 0));
      if ($urandom_range(3, 0) == 0)
        short_trial(r, c, int'($urandom_range((int'(pg) - 1) * TD, 1)));
      else
        digit_trial(r, c, int'($urandom_range(12, 0)));
    end

    finish_run();
  end
endmodule